// File: doc/BRIEF.md
# Processor Mode and Privilege Tracker

This block keeps the execution state of a processor core along two axes: whether the core runs ordinary code (thread mode) or services an exception (handler mode), and whether the running code is privileged or unprivileged. It is a small piece of control logic that sits beside the core's exception sequencer. It is driven by a control-register write strobe with one data bit, an exception-entry pulse and an exception-return pulse.

Thread code can give up privilege by writing the control bit, and it cannot take privilege back. Handler mode is always privileged. While an exception is active, handler code may rewrite the stored thread level, and that level applies once the last nested exception returns. Any write attempted from unprivileged thread code is discarded and reported on an error output. A depth counter follows nested exceptions.

Top module: `mpt_mode_tracker`

## Requirements
- R1: After reset the block reports thread mode (`mode_handler`=0), privileged level (`priv_level`=1) and `ctl_err`=0.
- R2: In privileged thread mode, a write with `ctl_wdata`=1 makes `priv_level` 0 from the next cycle on. A write with `ctl_wdata`=0 leaves `priv_level` at 1.
- R3: In unprivileged thread mode a control write has no effect, and `priv_level` stays 0.
- R4: A control write made while `priv_level`=0 raises `ctl_err` for exactly the next cycle. A write made while `priv_level`=1 never raises it.
- R5: An `exc_enter` pulse makes `mode_handler`=1 and `priv_level`=1 from the next cycle on.
- R6: When the last active exception returns, the block goes back to thread mode at the stored thread level, which is unprivileged if it was so before entry.
- R7: Entries nest. Thread mode comes back only after as many `exc_return` pulses as `exc_enter` pulses have been seen.
- R8: An `exc_return` pulse while in thread mode with no entry in the same cycle is ignored, and the mode and level stay the same.
- R9: Nesting depth saturates at 2^NEST_W-1. Entries beyond that are ignored, so exactly 2^NEST_W-1 returns reach thread mode.
- R10: A control write in handler mode sets the thread level used after the final return (1 = unprivileged) and raises no error.
- R11: `exc_enter` and `exc_return` in the same cycle leave an active depth unchanged. In thread mode the pair enters handler mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ctl_wr | input | 1 | Control-register write strobe |
| ctl_wdata | input | 1 | Written thread level: 1 = unprivileged, 0 = privileged |
| exc_enter | input | 1 | One-cycle exception-entry pulse |
| exc_return | input | 1 | One-cycle exception-return pulse |
| mode_handler | output | 1 | 1 = handler mode, 0 = thread mode |
| priv_level | output | 1 | 1 = privileged, 0 = unprivileged |
| ctl_err | output | 1 | Pulse marking a rejected control write |

## Verification
The assertions check these rules on every cycle:
- handler mode is always privileged;
- every entry lands in handler mode;
- unprivileged thread code stays unprivileged until an entry;
- a return in thread mode does nothing;
- every error pulse is caused by a rejected write.

Only the bench's scenarios can show the rules that need history. These are that the nesting depth is counted exactly (including saturation), that the stored thread level comes back on the final return, and that a handler-mode write changes the level seen after that return.

// File: rtl/mpt_pkg.sv
package mpt_pkg;
   typedef enum logic {
      MODE_THREAD  = 1'b0,
      MODE_HANDLER = 1'b1
   } mpt_mode_e;

   typedef enum logic {
      LVL_USER = 1'b0,
      LVL_PRIV = 1'b1
   } mpt_lvl_e;

   function automatic int unsigned mpt_depth_max(input int unsigned w);
      return (1 << w) - 1;
   endfunction
endpackage

// File: rtl/mpt_nest_ctr.sv
module mpt_nest_ctr #(
   parameter int unsigned NEST_W = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic enter,
   input  logic ret,
   output logic active
);
   localparam logic [NEST_W-1:0] DEPTH_MAX = {NEST_W{1'b1}};
   localparam logic [NEST_W-1:0] DEPTH_ONE = {{(NEST_W-1){1'b0}}, 1'b1};

   initial begin
      if (NEST_W < 1 || NEST_W > 16)
         $error("mpt_nest_ctr: NEST_W must be in 1..16");
   end

   logic [NEST_W-1:0] depth_q;
   logic [NEST_W-1:0] depth_d;
   logic              inc;
   logic              dec;

   always_comb begin
      inc     = enter && (depth_q != DEPTH_MAX);
      dec     = ret && (depth_q != '0);
      depth_d = depth_q;
      if (inc && !dec)
         depth_d = depth_q + DEPTH_ONE;
      else if (dec && !inc)
         depth_d = depth_q - DEPTH_ONE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) depth_q <= '0;
      else        depth_q <= depth_d;
   end

   assign active = (depth_q != '0);
endmodule

// File: rtl/mpt_thread_lvl.sv
module mpt_thread_lvl (
   input  logic clk,
   input  logic rst_n,
   input  logic wr,
   input  logic wdata,
   input  logic allow,
   output logic thread_user
);
   logic user_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            user_q <= 1'b0;
      else if (wr && allow)  user_q <= wdata;
   end

   assign thread_user = user_q;
endmodule

// File: rtl/mpt_err_flag.sv
module mpt_err_flag #(
   parameter bit ERR_REG = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bad_wr,
   output logic err
);
   generate
      if (ERR_REG) begin : g_reg
         logic err_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) err_q <= 1'b0;
            else        err_q <= bad_wr;
         end
         assign err = err_q;
      end else begin : g_comb
         logic unused_clk;
         assign unused_clk = clk ^ rst_n;
         assign err = bad_wr;
      end
   endgenerate
endmodule

// File: rtl/mpt_mode_tracker.sv
module mpt_mode_tracker #(
   parameter int unsigned NEST_W  = 4,
   parameter bit          ERR_REG = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ctl_wr,
   input  logic ctl_wdata,
   input  logic exc_enter,
   input  logic exc_return,
   output logic mode_handler,
   output logic priv_level,
   output logic ctl_err
);
   import mpt_pkg::*;

   localparam int unsigned DEPTH_MAX = mpt_depth_max(NEST_W);

   initial begin
      if (DEPTH_MAX < 1)
         $error("mpt_mode_tracker: nesting depth must allow one exception");
   end

   logic      exc_active;
   logic      thread_user;
   mpt_mode_e mode;
   mpt_lvl_e  lvl;

   mpt_nest_ctr #(.NEST_W(NEST_W)) u_nest (
      .clk    (clk),
      .rst_n  (rst_n),
      .enter  (exc_enter),
      .ret    (exc_return),
      .active (exc_active)
   );

   assign mode = exc_active ? MODE_HANDLER : MODE_THREAD;
   assign lvl  = (mode == MODE_HANDLER || !thread_user) ? LVL_PRIV : LVL_USER;

   mpt_thread_lvl u_lvl (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr          (ctl_wr),
      .wdata       (ctl_wdata),
      .allow       (lvl == LVL_PRIV),
      .thread_user (thread_user)
   );

   mpt_err_flag #(.ERR_REG(ERR_REG)) u_err (
      .clk    (clk),
      .rst_n  (rst_n),
      .bad_wr (ctl_wr && (lvl == LVL_USER)),
      .err    (ctl_err)
   );

   assign mode_handler = (mode == MODE_HANDLER);
   assign priv_level   = (lvl == LVL_PRIV);
endmodule

// File: rtl/mpt_mode_tracker_chk.sv
module mpt_mode_tracker_chk #(
   parameter bit ERR_REG = 1'b1
) (
   input logic clk,
   input logic rst_n,
   input logic ctl_wr,
   input logic ctl_wdata,
   input logic exc_enter,
   input logic exc_return,
   input logic mode_handler,
   input logic priv_level,
   input logic ctl_err
);
   a_r5_handler_priv: assert property (@(posedge clk) disable iff (!rst_n)
      mode_handler |-> priv_level);

   a_r5_enter_handler: assert property (@(posedge clk) disable iff (!rst_n)
      exc_enter |=> (mode_handler && priv_level));

   a_r3_user_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_handler && !priv_level && !exc_enter) |=> !priv_level);

   a_r8_stray_return: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_handler && exc_return && !exc_enter) |=> !mode_handler);

   a_r2_drop_priv: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_handler && priv_level && ctl_wr && ctl_wdata && !exc_enter) |=> !priv_level);

   generate
      if (ERR_REG) begin : g_reg_chk
         a_r4_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
            ctl_err |-> $past(ctl_wr && !priv_level));
         a_r4_err_raise: assert property (@(posedge clk) disable iff (!rst_n)
            (ctl_wr && !priv_level) |=> ctl_err);
      end else begin : g_comb_chk
         a_r4_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
            ctl_err |-> (ctl_wr && !priv_level));
      end
   endgenerate
endmodule

bind mpt_mode_tracker mpt_mode_tracker_chk #(.ERR_REG(ERR_REG)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .ctl_wr       (ctl_wr),
   .ctl_wdata    (ctl_wdata),
   .exc_enter    (exc_enter),
   .exc_return   (exc_return),
   .mode_handler (mode_handler),
   .priv_level   (priv_level),
   .ctl_err      (ctl_err)
);

// File: tb/sim_mpt_mode_tracker.sv
`timescale 1ns/1ps
module sim_mpt_mode_tracker;
   localparam int NEST_W = 4;
   localparam int DMAX   = (1 << NEST_W) - 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ctl_wr = 1'b0, ctl_wdata = 1'b0, exc_enter = 1'b0, exc_return = 1'b0;
   logic mode_handler, priv_level, ctl_err;

   always #2 clk = ~clk;

   mpt_mode_tracker #(.NEST_W(NEST_W), .ERR_REG(1'b1)) u0 (
      .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
      .exc_enter(exc_enter), .exc_return(exc_return),
      .mode_handler(mode_handler), .priv_level(priv_level), .ctl_err(ctl_err));

   typedef struct {
      logic  mode;
      logic  priv;
      logic  err;
      string tag;
   } exp_t;

   exp_t exp_q[$];
   int checks = 0;
   int failures = 0;
   int m_depth = 0;
   logic m_user = 1'b0;
   bit done = 1'b0;

   task automatic compare(input exp_t e);
      checks++;
      if (mode_handler !== e.mode || priv_level !== e.priv || ctl_err !== e.err) begin
         failures++;
         $display("FAIL %s: actual mode=%b priv=%b err=%b expected mode=%b priv=%b err=%b",
                  e.tag, mode_handler, priv_level, ctl_err, e.mode, e.priv, e.err);
      end
   endtask

   // driver: one cycle of stimulus, reference model, push expectation
   task automatic step(input logic wr, input logic wd, input logic en,
                       input logic rt, input string tag);
      exp_t e;
      logic cur_priv;
      logic inc;
      logic dec;
      @(negedge clk);
      ctl_wr = wr; ctl_wdata = wd; exc_enter = en; exc_return = rt;
      cur_priv = (m_depth != 0) || !m_user;
      e.err = wr && !cur_priv;
      if (wr && cur_priv) m_user = wd;
      inc = en && (m_depth != DMAX);
      dec = rt && (m_depth != 0);
      m_depth = m_depth + int'(inc) - int'(dec);
      e.mode = (m_depth != 0);
      e.priv = (m_depth != 0) || !m_user;
      e.tag  = tag;
      exp_q.push_back(e);
   endtask

   // monitor: sample just after each rising edge
   always @(posedge clk) begin
      #1;
      if (exp_q.size() > 0) compare(exp_q.pop_front());
   end

   initial begin
      exp_t r;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #0.5;
      r.mode = 1'b0; r.priv = 1'b1; r.err = 1'b0; r.tag = "R1 reset state";
      compare(r);

      step(0,0,0,0, "R1 idle after reset");
      step(1,0,0,0, "R2 privileged write of 0 keeps level");
      step(1,0,0,0, "R4 no error on privileged write");
      step(1,1,0,0, "R2 drop to user");
      step(1,0,0,0, "R3 R4 illegal restore ignored with error");
      step(0,0,0,0, "R4 error lasts one cycle");
      step(1,1,0,0, "R4 any user write errors");
      step(0,0,0,1, "R8 stray return ignored");
      step(0,0,1,0, "R5 enter handler privileged");
      step(0,0,0,1, "R6 return restores user");
      step(0,0,1,0, "R7 nest level 1");
      step(0,0,1,0, "R7 nest level 2");
      step(0,0,1,0, "R7 nest level 3");
      step(0,0,0,1, "R7 still handler after 1 return");
      step(0,0,1,1, "R11 enter and return together keep depth");
      step(0,0,0,1, "R7 still handler after 2 returns");
      step(1,0,0,0, "R10 handler write restores thread level");
      step(0,0,0,1, "R7 R10 final return privileged thread");
      step(0,0,1,1, "R11 pair in thread enters handler");
      step(1,1,0,0, "R10 handler write sets user");
      step(0,0,0,1, "R10 return to user thread");
      for (int i = 0; i < DMAX + 3; i++)
         step(0,0,1,0, "R9 saturating entry");
      for (int i = 0; i < DMAX - 1; i++)
         step(0,0,0,1, "R9 handler until last return");
      step(0,0,0,1, "R9 max returns reach thread");
      step(0,0,0,0, "R3 user kept after saturation run");
      repeat (3) @(negedge clk);
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (20000) @(posedge clk);
            checks++; failures++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule